// File: doc/BRIEF.md
# Shared-Bus Interconnect with Round-Robin Arbiter

This block joins several bus masters to several bus slaves over a single shared path. Each direction has its own data bus, and no tristate is used. A master opens a transfer by raising its cycle and strobe lines. A registered round-robin arbiter then awards the path to one requesting master. That master keeps the path until it drops its cycle line.

The awarded master's address, write data, write enable and byte selects are broadcast to every slave. The upper address bits pick exactly one slave region, and only that slave receives the strobe. The decoded slave's read data is broadcast to all masters. Its acknowledge is returned only to the awarded master.

Addresses that fall in no slave region are answered by the interconnect itself with a one-cycle error pulse. This keeps a master from stalling forever on an empty region.

Top module: `shared_bus_ic`

## Requirements
- R1: While rst_ni is low, every slave strobe, master acknowledge and master error is 0, and m_rdat_o is 0.
- R2: The path is awarded on a clock edge. From idle, no slave strobe or master acknowledge appears in the same cycle in which a master first raises cycle and strobe. They can appear only after the next rising edge.
- R3: Among masters that have cycle asserted, the award goes round-robin. The search starts at the index after the last awarded master and wraps at the top. After reset, master 0 has first priority.
- R4: While the awarded master keeps its cycle line high, the award does not move, even when other masters request. When it drops cycle, the next requester in round-robin order is awarded on the following edge.
- R5: s_adr_o, s_wdat_o, s_we_o and s_sel_o equal the awarded master's address, write data, write enable and byte selects.
- R6: When the awarded master has cycle and strobe high and address bits 31:28 equal k with k below 8, only s_stb_o[k] is high. In every other case all slave strobes are low.
- R7: m_rdat_o carries the read data of the slave decoded from the broadcast address. It is 0 when no master is awarded or the address decodes to no slave.
- R8: m_ack_o has at most the awarded master's bit set. That bit is high only while the decoded slave is strobed and that same slave raises its acknowledge. Acknowledges from other slaves are ignored.
- R9: A strobed access whose bits 31:28 are 8 to 15 strobes no slave. It gets an error pulse on the awarded master's m_err_o bit on the edge after the access is awarded. The pulse is exactly one cycle wide.
- R10: When no master holds the award, all slave strobes, master acknowledges and master errors are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_cyc_i | input | N_MST | Per-master cycle (bus request and hold) |
| m_stb_i | input | N_MST | Per-master strobe |
| m_we_i | input | N_MST | Per-master write enable |
| m_sel_i | input | N_MST*DW/8 | Per-master byte selects, packed |
| m_adr_i | input | N_MST*AW | Per-master address, packed |
| m_wdat_i | input | N_MST*DW | Per-master write data, packed |
| m_rdat_o | output | DW | Read data broadcast to all masters |
| m_ack_o | output | N_MST | Per-master acknowledge |
| m_err_o | output | N_MST | Per-master error for unmapped addresses |
| s_adr_o | output | AW | Broadcast address |
| s_wdat_o | output | DW | Broadcast write data |
| s_we_o | output | 1 | Broadcast write enable |
| s_sel_o | output | DW/8 | Broadcast byte selects |
| s_stb_o | output | N_SLV | Per-slave routed strobe |
| s_rdat_i | input | N_SLV*DW | Per-slave read data, packed |
| s_ack_i | input | N_SLV | Per-slave acknowledge |

## Verification
The award is the only registered step on the normal path. A request raised between edges is awarded at the next rising edge. From then on, the broadcast signals, the routed strobe, the read data and the acknowledge follow the inputs within the same cycle. The error pulse comes one edge after the award and lasts one cycle. The bench drives inputs at the falling edge. It first checks, right after driving, that nothing has leaked through before the award edge. It then checks the awarded outputs at the next falling edge, and follows unmapped accesses for two more falling edges to see the error pulse rise and fall.

// File: rtl/shared_bus_pkg.sv
package shared_bus_pkg;
  localparam int unsigned SB_PORTS      = 8;
  localparam int unsigned SB_ADDR_W     = 32;
  localparam int unsigned SB_DATA_W     = 32;
  localparam int unsigned SB_REGION_LSB = 28;

  function automatic int unsigned sb_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sb_rr_arbiter.sv
module sb_rr_arbiter
  import shared_bus_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IW = sb_idx_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          gnt_vld_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic          vld_q;
  logic [IW-1:0] idx_q;
  logic          keep;
  logic          hi_found, lo_found, found;
  logic [IW-1:0] hi_idx, lo_idx, pick;

  // lowest requester above the pointer wins, else lowest at or below it
  always_comb begin
    hi_found = 1'b0;
    lo_found = 1'b0;
    hi_idx   = '0;
    lo_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        if (IW'(i) > idx_q) begin
          hi_found = 1'b1;
          hi_idx   = IW'(i);
        end else begin
          lo_found = 1'b1;
          lo_idx   = IW'(i);
        end
      end
    end
    found = hi_found | lo_found;
    pick  = hi_found ? hi_idx : lo_idx;
  end

  assign keep = vld_q & req_i[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= IW'(N - 1);
    end else if (!keep) begin
      vld_q <= found;
      if (found) idx_q <= pick;
    end
  end

  assign gnt_vld_o = vld_q;
  assign gnt_idx_o = idx_q;
endmodule

// File: rtl/sb_addr_decoder.sv
module sb_addr_decoder #(
  parameter int unsigned N_SLV = 8,
  parameter int unsigned RW    = 4
) (
  input  logic [RW-1:0]    region_i,
  output logic             hit_o,
  output logic [N_SLV-1:0] sel_o
);
  for (genvar j = 0; j < N_SLV; j++) begin : g_region
    assign sel_o[j] = (region_i == RW'(j));
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/sb_onehot_mux.sv
module sb_onehot_mux #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 32
) (
  input  logic [N-1:0]   sel_i,
  input  logic [N*W-1:0] data_i,
  output logic [W-1:0]   data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) data_o = data_o | data_i[i*W +: W];
    end
  end
endmodule

// File: rtl/shared_bus_ic.sv
module shared_bus_ic
  import shared_bus_pkg::*;
#(
  parameter int unsigned N_MST      = SB_PORTS,
  parameter int unsigned N_SLV      = SB_PORTS,
  parameter int unsigned AW         = SB_ADDR_W,
  parameter int unsigned DW         = SB_DATA_W,
  parameter int unsigned REGION_LSB = SB_REGION_LSB,
  localparam int unsigned SW        = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MST-1:0]    m_cyc_i,
  input  logic [N_MST-1:0]    m_stb_i,
  input  logic [N_MST-1:0]    m_we_i,
  input  logic [N_MST*SW-1:0] m_sel_i,
  input  logic [N_MST*AW-1:0] m_adr_i,
  input  logic [N_MST*DW-1:0] m_wdat_i,
  output logic [DW-1:0]       m_rdat_o,
  output logic [N_MST-1:0]    m_ack_o,
  output logic [N_MST-1:0]    m_err_o,
  output logic [AW-1:0]       s_adr_o,
  output logic [DW-1:0]       s_wdat_o,
  output logic                s_we_o,
  output logic [SW-1:0]       s_sel_o,
  output logic [N_SLV-1:0]    s_stb_o,
  input  logic [N_SLV*DW-1:0] s_rdat_i,
  input  logic [N_SLV-1:0]    s_ack_i
);
  localparam int unsigned RW = AW - REGION_LSB;
  localparam int unsigned IW = sb_idx_w(N_MST);
  localparam int unsigned MW = 1 + SW + AW + DW;

  logic                 gnt_vld;
  logic [IW-1:0]        gnt_idx;
  logic [N_MST-1:0]     gnt_oh;
  logic [N_MST*MW-1:0]  m_pack;
  logic [MW-1:0]        cur;
  logic                 cur_req;
  logic                 hit;
  logic [N_SLV-1:0]     dec_oh;
  logic                 sel_ack;
  logic                 err_q;

  sb_rr_arbiter #(.N(N_MST)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (m_cyc_i),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx)
  );

  assign gnt_oh = gnt_vld ? ({{(N_MST-1){1'b0}}, 1'b1} << gnt_idx) : '0;

  for (genvar i = 0; i < N_MST; i++) begin : g_pack
    assign m_pack[i*MW +: MW] = {m_we_i[i], m_sel_i[i*SW +: SW],
                                 m_adr_i[i*AW +: AW], m_wdat_i[i*DW +: DW]};
  end

  sb_onehot_mux #(.N(N_MST), .W(MW)) u_fwd_mux (
    .sel_i  (gnt_oh),
    .data_i (m_pack),
    .data_o (cur)
  );

  assign {s_we_o, s_sel_o, s_adr_o, s_wdat_o} = cur;
  assign cur_req = |(gnt_oh & m_cyc_i & m_stb_i);

  sb_addr_decoder #(.N_SLV(N_SLV), .RW(RW)) u_dec (
    .region_i (s_adr_o[AW-1:REGION_LSB]),
    .hit_o    (hit),
    .sel_o    (dec_oh)
  );

  assign s_stb_o = dec_oh & {N_SLV{cur_req}};

  // idle address is zero, so gate the read mux with the award
  sb_onehot_mux #(.N(N_SLV), .W(DW)) u_ret_mux (
    .sel_i  (dec_oh & {N_SLV{gnt_vld}}),
    .data_i (s_rdat_i),
    .data_o (m_rdat_o)
  );

  assign sel_ack = |(s_ack_i & s_stb_o);
  assign m_ack_o = gnt_oh & {N_MST{sel_ack}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= cur_req & ~hit & ~err_q;
  end

  assign m_err_o = gnt_oh & {N_MST{err_q}};
endmodule

// File: rtl/sb_bus_checker.sv
module sb_bus_checker
  import shared_bus_pkg::*;
#(
  parameter int unsigned N_MST = 8,
  parameter int unsigned N_SLV = 8,
  localparam int unsigned IW   = sb_idx_w(N_MST)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gnt_vld_i,
  input logic [IW-1:0]    gnt_idx_i,
  input logic [N_MST-1:0] m_cyc_i,
  input logic [N_SLV-1:0] s_stb_o,
  input logic [N_MST-1:0] m_ack_o,
  input logic [N_MST-1:0] m_err_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_vld_i |-> (s_stb_o == '0 && m_ack_o == '0 && m_err_o == '0)); // R10

  AST_STB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_stb_o)); // R6

  AST_ACK_TO_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|m_ack_o) |-> (gnt_vld_i && m_ack_o[gnt_idx_i] && $onehot(m_ack_o))); // R8

  AST_ACK_NEEDS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|m_ack_o) |-> (|s_stb_o)); // R8

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|m_err_o) |=> !(|m_err_o)); // R9

  AST_ERR_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|m_err_o) |-> (s_stb_o == '0 && $past(s_stb_o) == '0)); // R9

  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_i && m_cyc_i[gnt_idx_i]) |=> (gnt_vld_i && gnt_idx_i == $past(gnt_idx_i))); // R4
endmodule

bind shared_bus_ic sb_bus_checker #(.N_MST(N_MST), .N_SLV(N_SLV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gnt_vld_i (gnt_vld),
  .gnt_idx_i (gnt_idx),
  .m_cyc_i   (m_cyc_i),
  .s_stb_o   (s_stb_o),
  .m_ack_o   (m_ack_o),
  .m_err_o   (m_err_o)
);

// File: tb/shared_bus_ic_tb.sv
`timescale 1ns/1ps
module shared_bus_ic_tb;
  localparam int NM = 8;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NM-1:0]    m_cyc, m_stb, m_we;
  logic [NM*4-1:0]  m_sel;
  logic [NM*32-1:0] m_adr, m_wdat;
  logic [31:0]      m_rdat;
  logic [NM-1:0]    m_ack, m_err;
  logic [31:0]      s_adr, s_wdat;
  logic             s_we;
  logic [3:0]       s_sel;
  logic [NS-1:0]    s_stb;
  logic [NS*32-1:0] s_rdat;
  logic [NS-1:0]    s_ack;

  logic [31:0] b_adr [NM];
  logic [31:0] b_wd  [NM];
  logic [3:0]  b_sel [NM];
  logic        ack_en;
  logic [NS-1:0] spur;

  int total = 0;
  int bad   = 0;
  int last  = NM - 1;

  shared_bus_ic u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_sel_i(m_sel),
    .m_adr_i(m_adr), .m_wdat_i(m_wdat), .m_rdat_o(m_rdat),
    .m_ack_o(m_ack), .m_err_o(m_err),
    .s_adr_o(s_adr), .s_wdat_o(s_wdat), .s_we_o(s_we), .s_sel_o(s_sel),
    .s_stb_o(s_stb), .s_rdat_i(s_rdat), .s_ack_i(s_ack)
  );

  function automatic logic [31:0] slv_val(input int j, input logic [31:0] a);
    return a ^ (32'h1357_9BDF + 32'(j) * 32'h0101_0101);
  endfunction

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      m_adr[i*32 +: 32]  = b_adr[i];
      m_wdat[i*32 +: 32] = b_wd[i];
      m_sel[i*4 +: 4]    = b_sel[i];
    end
    for (int j = 0; j < NS; j++) s_rdat[j*32 +: 32] = slv_val(j, s_adr);
    s_ack = (s_stb & {NS{ack_en}}) | spur;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_m(input int i, input logic c, input logic s, input logic [31:0] a,
                       input logic [31:0] d, input logic w, input logic [3:0] sl);
    m_cyc[i] = c; m_stb[i] = s; b_adr[i] = a; b_wd[i] = d; m_we[i] = w; b_sel[i] = sl;
  endtask

  task automatic drop_m(input int i);
    m_cyc[i] = 1'b0; m_stb[i] = 1'b0;
  endtask

  task automatic check_quiet(input string tag);
    check({tag, " stb"}, 32'(s_stb), 32'h0);
    check({tag, " ack"}, 32'(m_ack), 32'h0);
    check({tag, " err"}, 32'(m_err), 32'h0);
  endtask

  function automatic int rr_next(input int lst, input logic [NM-1:0] mask);
    for (int k = 1; k <= NM; k++) begin
      if (mask[(lst + k) % NM]) return (lst + k) % NM;
    end
    return -1;
  endfunction

  function automatic logic [31:0] rr_adr(input int m);
    return {4'(m), 28'h00A_0000 + 28'(m) * 28'h10};
  endfunction

  initial begin
    logic [NM-1:0] masks [4];
    masks[0] = 8'hFF; masks[1] = 8'hA6; masks[2] = 8'h81; masks[3] = 8'h10;
    m_cyc = '0; m_stb = '0; m_we = '0; ack_en = 1'b1; spur = '0;
    for (int i = 0; i < NM; i++) begin b_adr[i] = '0; b_wd[i] = '0; b_sel[i] = '0; end

    repeat (3) @(negedge clk);
    check_quiet("R1 reset");
    check("R1 reset rdat", m_rdat, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R10 idle after reset");

    // round robin: reset pointer gives master 0 first
    for (int t = 0; t < 4; t++) begin
      logic [NM-1:0] mask;
      mask = masks[t];
      for (int m = 0; m < NM; m++)
        if (mask[m]) set_m(m, 1'b1, 1'b1, rr_adr(m), 32'hC0DE_0000 + 32'(m), 1'b0, 4'hF);
      while (mask != '0) begin
        int e;
        @(negedge clk);
        e = rr_next(last, mask);
        check("R3 rr award", 32'(m_ack), 32'(1) << e);
        check("R5 rr addr", s_adr, rr_adr(e));
        check("R7 rr rdat", m_rdat, slv_val(e, rr_adr(e)));
        last = e;
        mask[e] = 1'b0;
        drop_m(e);
      end
      @(negedge clk);
      check_quiet("R10 rr idle");
    end

    // sweep every master against every region
    for (int m = 0; m < NM; m++) begin
      for (int r = 0; r < 16; r++) begin
        logic [31:0] a, d;
        a = {r[3:0], 28'h012_3000 + 28'(m) * 28'h100 + 28'(r) * 28'h4};
        d = 32'hD000_0000 ^ (32'(m) << 8) ^ 32'(r);
        set_m(m, 1'b1, 1'b1, a, d, r[0], r[3:0]);
        #1;
        check("R2 no early stb", 32'(s_stb), 32'h0);
        check("R2 no early ack", 32'(m_ack), 32'h0);
        @(negedge clk);
        check("R5 adr", s_adr, a);
        check("R5 wdat", s_wdat, d);
        check("R5 we", 32'(s_we), 32'(r[0]));
        check("R5 sel", 32'(s_sel), 32'(r[3:0]));
        check("R9 no err yet", 32'(m_err), 32'h0);
        if (r < NS) begin
          check("R6 stb", 32'(s_stb), 32'(1) << r);
          check("R8 ack", 32'(m_ack), 32'(1) << m);
          check("R7 rdat", m_rdat, slv_val(r, a));
        end else begin
          check("R9 unmapped stb", 32'(s_stb), 32'h0);
          check("R9 unmapped ack", 32'(m_ack), 32'h0);
          check("R7 unmapped rdat", m_rdat, 32'h0);
          @(negedge clk);
          check("R9 err", 32'(m_err), 32'(1) << m);
          @(negedge clk);
          check("R9 err one cycle", 32'(m_err), 32'h0);
        end
        drop_m(m);
        @(negedge clk);
        check_quiet("R10 release");
        last = m;
      end
    end

    // hold against a competing request
    set_m(2, 1'b1, 1'b1, rr_adr(2), 32'h2222_2222, 1'b1, 4'h3);
    @(negedge clk);
    check("R4 first award", 32'(m_ack), 32'h04);
    set_m(5, 1'b1, 1'b1, rr_adr(5), 32'h5555_5555, 1'b0, 4'hC);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R4 held ack", 32'(m_ack), 32'h04);
      check("R4 held stb", 32'(s_stb), 32'h04);
      check("R5 held wdat", s_wdat, 32'h2222_2222);
    end
    drop_m(2);
    @(negedge clk);
    check("R4 hand over", 32'(m_ack), 32'h20);
    check("R5 hand over wdat", s_wdat, 32'h5555_5555);
    drop_m(5);
    @(negedge clk);
    last = 5;

    // acknowledges from other slaves are ignored
    ack_en = 1'b0;
    spur = ~8'h40;
    set_m(3, 1'b1, 1'b1, rr_adr(6), 32'h3333_0000, 1'b1, 4'h1);
    @(negedge clk);
    check("R6 stb slave6", 32'(s_stb), 32'h40);
    check("R8 spurious ack ignored", 32'(m_ack), 32'h0);
    spur = 8'h40;
    #1;
    check("R8 selected ack", 32'(m_ack), 32'h08);
    drop_m(3);
    spur = '0;
    ack_en = 1'b1;
    @(negedge clk);
    check_quiet("R10 after spurious");

    // cycle without strobe: award but no slave strobe
    set_m(4, 1'b1, 1'b0, rr_adr(1), 32'h0, 1'b0, 4'h0);
    @(negedge clk);
    check("R6 no stb without strobe", 32'(s_stb), 32'h0);
    check("R8 no ack without strobe", 32'(m_ack), 32'h0);
    check("R5 addr without strobe", s_adr, rr_adr(1));
    drop_m(4);
    @(negedge clk);
    check_quiet("R10 final idle");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule